// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block gathers a parameterized set of level-sensitive hardware request lines and a small bank of software-settable request bits, one programmable priority per source. From all pending sources whose priority lies strictly above the running priority, it picks the highest one and presents it to the processor as a single interrupt line with a unique vector number. The vector number equals the source index. The software sources take indices 0 to N_SW-1, and hardware line k takes index N_SW+k.

Acknowledging the request raises the running priority to that of the served source. Acknowledge comes either from the hardware `iack_i` strobe or from a read of the acknowledge register. The priority that was preempted is pushed onto a small hardware LIFO. An end-of-interrupt write pops the LIFO back into the running priority, so nested routines unwind in order. Software can also write the running priority directly, for example to raise it to a ceiling while it uses a shared resource.

Register map, by word address: 0 running priority (read/write); 1 acknowledge (read); 2 end-of-interrupt (write); 3 software set (write) and software pending (read); 4 software clear (write); 16+i priority of source i.

Top module: `prio_intc`

## Requirements
- R1: After reset `irq_o` and `lifo_ovf_o` are 0, the running priority is 0, every source priority reads 0, and no software request is pending.
- R2: `irq_o` is raised only for a pending source whose priority is strictly greater than the running priority. Among those sources the highest priority wins, and on a tie the lowest source index wins. `vector_o` is that source index: software bit j gives j, and hardware line k gives 8+k with the defaults.
- R3: If a hardware line rises while its source qualifies, `irq_o` is high after the second rising clock edge that follows, which is within three cycles.
- R4: An acknowledge is a one-cycle `iack_i` pulse or a read of address 1. When `irq_o` is high, it pushes the running priority onto the LIFO, loads the served source's priority as the running priority, and drops `irq_o` in the next cycle. A read of address 1 returns `irq_o` in bit 15 and the vector in bits 8:0.
- R5: A write to address 2 (end-of-interrupt) pops the LIFO top into the running priority. If the LIFO is empty, the running priority becomes 0.
- R6: An acknowledge while the LIFO (default depth 4) is full discards the push and sets `lifo_ovf_o`, which then stays high until reset.
- R7: A write to address 0 loads bits 3:0 into the running priority. A read of address 0 returns it.
- R8: A write to address 3 sets the software requests whose bits 7:0 are 1. A write to address 4 clears them. A read of address 3 returns the pending bits.
- R9: A write to address 16+i loads bits 3:0 as the priority of source i. A read of that address returns it.
- R10: An acknowledge while `irq_o` is low leaves the running priority and the LIFO unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hw_req_i | input | N_HW | Level-sensitive hardware requests |
| iack_i | input | 1 | Hardware acknowledge strobe |
| wr_en_i | input | 1 | Register write enable |
| rd_en_i | input | 1 | Register read enable (needed for read-acknowledge) |
| addr_i | input | ADDR_W | Register word address |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data (combinational from address) |
| irq_o | output | 1 | Interrupt request to processor |
| vector_o | output | VEC_W | Vector of the presented request |
| cur_prio_o | output | PRIO_W | Running priority |
| lifo_ovf_o | output | 1 | Sticky LIFO overflow flag |

## Verification
Hardware lines are raised one at a time, then in pairs at equal priority, then at a higher priority while a lower one is being served. Together these separate the strict-greater rule, the lowest-index tie break and nested preemption. Software bits are set and cleared alone to show that both request banks feed the same selector. Repeated acknowledges, each followed by lowering the running priority, fill the LIFO past its depth to expose overflow handling. End-of-interrupt writes past the bottom of the LIFO show the return to priority 0. An acknowledge with nothing presented shows that it has no effect.

// File: rtl/intc_pkg.sv
// Package: register addresses and data width shared by the controller
// and its bench. Assumes word addressing on the register port.
package intc_pkg;
    localparam int DATA_W      = 16;
    localparam int A_CUR       = 0;
    localparam int A_ACK       = 1;
    localparam int A_EOI       = 2;
    localparam int A_SWSET     = 3;
    localparam int A_SWCLR     = 4;
    localparam int A_PRIO_BASE = 16;
endpackage

// File: rtl/intc_arbiter.sv
// Module: intc_arbiter
// Picks, among pending sources whose priority is strictly above the
// running priority, the one with the highest priority. Ties go to the
// lowest index. Purely combinational; assumes N_SRC >= 2.
module intc_arbiter #(
    parameter int N_SRC  = 24,
    parameter int PRIO_W = 4,
    localparam int SRC_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]             pend_i,
    input  logic [N_SRC-1:0][PRIO_W-1:0] prio_i,
    input  logic [PRIO_W-1:0]            cur_i,
    output logic                         valid_o,
    output logic [SRC_W-1:0]             idx_o,
    output logic [PRIO_W-1:0]            prio_o
);
    // Scan from the top index down so an equal priority at a lower index overrides.
    always_comb begin
        valid_o = 1'b0;
        idx_o   = '0;
        prio_o  = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (pend_i[i] && (prio_i[i] > cur_i) && (!valid_o || prio_i[i] >= prio_o)) begin
                valid_o = 1'b1;
                idx_o   = SRC_W'(i);
                prio_o  = prio_i[i];
            end
        end
    end
endmodule

// File: rtl/intc_lifo.sv
// Module: intc_lifo
// Stack of preempted priorities. A push while full is dropped (the
// owner flags overflow) and a pop while empty does nothing. Assumes push
// and pop never arrive in the same cycle, and DEPTH >= 2.
module intc_lifo #(
    parameter int DEPTH  = 4,
    parameter int WIDTH  = 4,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             pop_i,
    output logic [WIDTH-1:0] top_o,
    output logic             empty_o,
    output logic             full_o
);
    logic [DEPTH-1:0][WIDTH-1:0] mem_r;
    logic [CNT_W-1:0]            cnt_r;

    assign empty_o = (cnt_r == '0);
    assign full_o  = (cnt_r == CNT_W'(DEPTH));
    assign top_o   = empty_o ? '0 : mem_r[PTR_W'(cnt_r - 1'b1)];

    // Store on push and move the fill count on push or pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_r <= '0;
            mem_r <= '0;
        end else if (push_i && !full_o) begin
            mem_r[PTR_W'(cnt_r)] <= data_i;
            cnt_r                <= cnt_r + 1'b1;
        end else if (pop_i && !empty_o) begin
            cnt_r <= cnt_r - 1'b1;
        end
    end

    assert_lifo_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !full_o) |=> !empty_o);
    assert_lifo_drain_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !empty_o) |=> !full_o);
endmodule

// File: rtl/prio_intc.sv
// Module: prio_intc
// Preemptive priority interrupt controller. Hardware lines pass through
// one register, selection is combinational, and irq/vector are registered,
// so a request reaches irq_o two edges after it arrives. An acknowledge
// takes precedence over a same-cycle write to the running priority or
// end-of-interrupt.
module prio_intc #(
    parameter int N_HW   = 16,
    parameter int N_SW   = 8,
    parameter int PRIO_W = 4,
    parameter int VEC_W  = 9,
    parameter int LIFO_D = 4,
    parameter int ADDR_W = 6,
    parameter int DATA_W = intc_pkg::DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_HW-1:0]   hw_req_i,
    input  logic              iack_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o,
    output logic [VEC_W-1:0]  vector_o,
    output logic [PRIO_W-1:0] cur_prio_o,
    output logic              lifo_ovf_o
);
    import intc_pkg::*;

    localparam int N_SRC = N_SW + N_HW;
    localparam int SRC_W = $clog2(N_SRC);

    logic [N_HW-1:0]             hw_q;
    logic [N_SW-1:0]             sw_q;
    logic [N_SRC-1:0][PRIO_W-1:0] prio_r;
    logic [PRIO_W-1:0]           cur_r, vprio_r;
    logic                        irq_r, ovf_r;
    logic [VEC_W-1:0]            vec_r;

    logic                        sel_valid;
    logic [SRC_W-1:0]            sel_idx;
    logic [PRIO_W-1:0]           sel_prio;
    logic                        ack, eoi, cur_wr;
    logic [PRIO_W-1:0]           lifo_top;
    logic                        lifo_empty, lifo_full;

    intc_arbiter #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_arb (
        .pend_i (({hw_q, sw_q})),
        .prio_i (prio_r),
        .cur_i  (cur_r),
        .valid_o(sel_valid),
        .idx_o  (sel_idx),
        .prio_o (sel_prio)
    );

    // Decode the register-port strobes; an acknowledge blocks priority writes.
    always_comb begin
        ack    = (iack_i || (rd_en_i && addr_i == ADDR_W'(A_ACK))) && irq_r;
        eoi    = wr_en_i && (addr_i == ADDR_W'(A_EOI)) && !ack;
        cur_wr = wr_en_i && (addr_i == ADDR_W'(A_CUR)) && !ack;
    end

    intc_lifo #(.DEPTH(LIFO_D), .WIDTH(PRIO_W)) u_lifo (
        .clk    (clk),
        .rst_n  (rst_n),
        .push_i (ack),
        .data_i (cur_r),
        .pop_i  (eoi),
        .top_o  (lifo_top),
        .empty_o(lifo_empty),
        .full_o (lifo_full)
    );

    // Register the hardware lines and the presented request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hw_q    <= '0;
            irq_r   <= 1'b0;
            vec_r   <= '0;
            vprio_r <= '0;
        end else begin
            hw_q    <= hw_req_i;
            irq_r   <= sel_valid && !ack;
            vec_r   <= VEC_W'(sel_idx);
            vprio_r <= sel_prio;
        end
    end

    // Running priority: acknowledge, end-of-interrupt or direct write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_r <= '0;
            ovf_r <= 1'b0;
        end else begin
            if (ack && lifo_full) ovf_r <= 1'b1;
            if (ack)         cur_r <= vprio_r;
            else if (eoi)    cur_r <= lifo_top;
            else if (cur_wr) cur_r <= wdata_i[PRIO_W-1:0];
        end
    end

    // Software request bits: set and clear by mask.
    always_ff @(posedge clk) begin
        if (!rst_n) sw_q <= '0;
        else if (wr_en_i && addr_i == ADDR_W'(A_SWSET)) sw_q <= sw_q | wdata_i[N_SW-1:0];
        else if (wr_en_i && addr_i == ADDR_W'(A_SWCLR)) sw_q <= sw_q & ~wdata_i[N_SW-1:0];
    end

    for (genvar g = 0; g < N_SRC; g++) begin : g_prio
        // Per-source priority register written at its own address.
        always_ff @(posedge clk) begin
            if (!rst_n) prio_r[g] <= '0;
            else if (wr_en_i && addr_i == ADDR_W'(A_PRIO_BASE + g)) prio_r[g] <= wdata_i[PRIO_W-1:0];
        end
    end

    // Read multiplexer.
    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_W'(A_CUR)) begin
            rdata_o[PRIO_W-1:0] = cur_r;
        end else if (addr_i == ADDR_W'(A_ACK)) begin
            rdata_o[DATA_W-1]  = irq_r;
            rdata_o[VEC_W-1:0] = vec_r;
        end else if (addr_i == ADDR_W'(A_SWSET)) begin
            rdata_o[N_SW-1:0] = sw_q;
        end else begin
            for (int i = 0; i < N_SRC; i++)
                if (addr_i == ADDR_W'(A_PRIO_BASE + i)) rdata_o[PRIO_W-1:0] = prio_r[i];
        end
    end

    assign irq_o      = irq_r;
    assign vector_o   = vec_r;
    assign cur_prio_o = cur_r;
    assign lifo_ovf_o = ovf_r;

    assert_ack_loads_prio_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> (cur_prio_o == $past(vprio_r)));
    assert_ack_drops_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !irq_o);
    assert_overflow_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && lifo_full) |=> lifo_ovf_o);
    assert_eoi_empty_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && lifo_empty) |=> (cur_prio_o == '0));
    assert_idle_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (iack_i && !irq_o && !wr_en_i) |=> $stable(cur_prio_o));
endmodule

// File: tb/sim_prio_intc.sv
module sim_prio_intc;
    localparam int NH = 16, NS = 8, NSRC = NH + NS, DEPTH = 4;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [NH-1:0] hw_req = '0;
    logic        iack = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [5:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq, ovf;
    logic [8:0]  vector;
    logic [3:0]  cur;

    int compared = 0, mismatched = 0;
    bit done = 0;

    prio_intc u0 (.clk(clk), .rst_n(rst_n), .hw_req_i(hw_req), .iack_i(iack),
        .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .irq_o(irq), .vector_o(vector), .cur_prio_o(cur),
        .lifo_ovf_o(ovf));

    always #5 clk = ~clk;

    // Behavioural reference model
    int  m_prio [NSRC];
    bit  m_sw [NS];
    bit  m_hw [NH];
    int  m_cur, m_vec, m_vprio;
    bit  m_irq, m_ovf;
    int  m_stack [$];

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_prio[i]) m_prio[i] = 0;
            foreach (m_sw[i]) m_sw[i] = 0;
            foreach (m_hw[i]) m_hw[i] = 0;
            m_cur = 0; m_vec = 0; m_vprio = 0; m_irq = 0; m_ovf = 0;
            m_stack.delete();
        end else begin
            bit ack, found;
            int best, bi;
            ack = (iack || (rd_en && addr == 1)) && m_irq;
            found = 0; best = 0; bi = 0;
            for (int i = 0; i < NSRC; i++) begin
                bit p;
                p = (i < NS) ? m_sw[i] : m_hw[i - NS];
                if (p && m_prio[i] > m_cur && (!found || m_prio[i] > best)) begin
                    found = 1; best = m_prio[i]; bi = i;
                end
            end
            if (ack) begin
                if (m_stack.size() < DEPTH) m_stack.push_back(m_cur);
                else m_ovf = 1;
                m_cur = m_vprio;
            end else if (wr_en && addr == 2) begin
                m_cur = (m_stack.size() > 0) ? m_stack.pop_back() : 0;
            end else if (wr_en && addr == 0) begin
                m_cur = wdata & 15;
            end
            if (wr_en && addr == 3) for (int j = 0; j < NS; j++) if (wdata[j]) m_sw[j] = 1;
            if (wr_en && addr == 4) for (int j = 0; j < NS; j++) if (wdata[j]) m_sw[j] = 0;
            if (wr_en && addr >= 16 && addr < 16 + NSRC) m_prio[addr - 16] = wdata & 15;
            foreach (m_hw[i]) m_hw[i] = hw_req[i];
            m_irq = found && !ack;
            m_vec = bi; m_vprio = best;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare every cycle against the model (R2 R4 R5 R6 R7)
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(irq == m_irq, "R2 irq", irq, m_irq);
            if (m_irq) chk(vector == m_vec, "R2 vector", vector, m_vec);
            chk(cur == m_cur, "R5 R7 cur", cur, m_cur);
            chk(ovf == m_ovf, "R6 ovf", ovf, m_ovf);
        end
    end

    task automatic wr(input int a, input int d);
        @(negedge clk); #2; wr_en = 1; addr = 6'(a); wdata = 16'(d);
        @(negedge clk); #2; wr_en = 0;
    endtask

    task automatic rd(input int a, input int exp, input string tag);
        @(negedge clk); #2; rd_en = 1; addr = 6'(a); #1;
        chk(rdata == 16'(exp), tag, rdata, exp);
        @(negedge clk); #2; rd_en = 0;
    endtask

    task automatic pulse_ack();
        @(negedge clk); #2; iack = 1;
        @(negedge clk); #2; iack = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    initial begin
        #200_000;
        if (!done) begin
            mismatched++; compared++;
            $display("FAIL watchdog expired");
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #2; rst_n = 1;
        @(negedge clk); #2;
        // R1 reset state
        chk(irq == 0 && cur == 0 && ovf == 0, "R1 reset outputs", {irq, cur, ovf}, 0);
        rd(16 + 3, 0, "R1 prio reset");
        rd(3, 0, "R1 sw reset");
        // R9 priority programming
        wr(16 + 8, 5); wr(16 + 9, 5); wr(16 + 10, 9); wr(16 + 0, 3);
        rd(16 + 10, 9, "R9 prio readback");
        // R3 latency: hw line 1 = source 9
        @(negedge clk); #2; hw_req[1] = 1;
        @(negedge clk); chk(irq == 0, "R3 one edge", irq, 0);
        @(negedge clk); chk(irq == 1, "R3 two edges", irq, 1);
        chk(vector == 9, "R2 single vector", vector, 9);
        // R2 tie: lowest index wins
        #2; hw_req[0] = 1; idle(3);
        chk(vector == 8, "R2 tie lowest index", vector, 8);
        // R7 running priority write, strict greater
        wr(0, 5); idle(2);
        chk(irq == 0, "R7 R2 equal prio blocked", irq, 0);
        rd(0, 5, "R7 readback");
        wr(0, 0); idle(3);
        chk(irq == 1, "R7 lowered", irq, 1);
        // R4 hardware acknowledge
        pulse_ack();
        chk(irq == 0, "R4 irq drops", irq, 0);
        chk(cur == 5, "R4 cur loaded", cur, 5);
        // nested preemption and read-acknowledge
        hw_req[2] = 1; idle(3);
        chk(irq == 1 && vector == 10, "R2 preempt vector", vector, 10);
        rd(1, 16'h8000 | 10, "R4 ack read");
        chk(cur == 9, "R4 nested cur", cur, 9);
        // R5 end-of-interrupt unwinding
        wr(2, 0); chk(cur == 5, "R5 pop", cur, 5);
        wr(2, 0); chk(cur == 0, "R5 pop bottom", cur, 0);
        wr(2, 0); chk(cur == 0, "R5 pop empty", cur, 0);
        // R8 software requests
        hw_req = '0; idle(3);
        wr(3, 1); idle(3);
        chk(irq == 1 && vector == 0, "R8 sw set", vector, 0);
        rd(3, 1, "R8 sw readback");
        wr(4, 1); idle(3);
        chk(irq == 0, "R8 sw clear", irq, 0);
        // R6 overflow of the LIFO
        hw_req[2] = 1;
        for (int k = 0; k < DEPTH + 1; k++) begin
            idle(3);
            if (k == DEPTH) chk(ovf == 0, "R6 full not yet ovf", ovf, 0);
            pulse_ack();
            wr(0, 0);
        end
        chk(ovf == 1, "R6 overflow", ovf, 1);
        // R10 acknowledge with nothing presented
        wr(0, 15); idle(3);
        chk(irq == 0, "R10 irq idle", irq, 0);
        pulse_ack(); idle(1);
        chk(cur == 15, "R10 cur unchanged", cur, 15);
        wr(2, 0);
        chk(cur == 0, "R10 stack unchanged", cur, 0);
        idle(4);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule